// File: doc/BRIEF.md
# Register-Driven Half-Duplex SPI Command Engine

This block is a SPI host that runs one command at a time. Software writes into a small byte-addressable register space. It sets an 8-bit command opcode, a transmit length, a receive length and a chip-select number, and it fills a 64-byte data buffer with the bytes to send. It then sets a start bit. The engine drives the chosen chip select low and sends the opcode, then the buffered transmit bytes. After that it clocks in the requested number of receive bytes and writes each one back into the same buffer, directly behind the transmit bytes. A busy flag reads 1 until the last bit is done.

The register space takes 32-bit word writes, with one byte enable per lane, so single bytes can be written as well as whole words. Reads return the aligned 32-bit word. The serial side uses SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and the most-significant bit goes first. The serial clock is the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all four chip-select outputs are high, the serial clock and data outputs are low, and the control word at address 0x00 reads 0.
- R2: The register map is as follows. The opcode is at 0x00 bits 7:0. The chip-select number is the low two bits of byte 0x1D, which is word 0x1C bits 9:8. The transmit count is byte 0x48, which is word 0x48 bits 7:0. The receive count is byte 0x4B, which is word 0x48 bits 31:24. Buffer byte i is at 0x80+i, so word 0x80+4n bits 8k+7:8k hold byte 4n+k. Each byte-enable bit writes only its own lane.
- R3: Writing 1 to bit 16 of word 0x00 while idle starts a command. In that write, byte lane 0 also supplies the opcode when its enable is set. Bits 16 and 20 always read 0.
- R4: Bit 31 of word 0x00 reads 1 from the cycle after the start write until the command ends, and reads 0 afterwards.
- R5: During a command, the data output sends the opcode and then the effective transmit bytes, most-significant bit first. The data output is held low during the receive bytes. The command is exactly 8*(1+etx+erx) serial clock pulses long.
- R6: Received byte j, sampled on rising edges, is stored at buffer position etx+j and is read back at 0x80+etx+j.
- R7: While busy, only the chip-select output selected by the chip-select number is low, and it stays low without a break. When idle, all chip selects are high and the serial clock is low.
- R8: While busy, writes to the opcode, counts, chip-select number and buffer are ignored.
- R9: The effective transmit count etx is min(tx, 64). The effective receive count erx is min(rx, 64-etx). A receive count of 0 ends the command after the last transmit byte.
- R10: One serial clock period lasts CLK_DIV system clock cycles (4 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Aligned word at bus_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The main function is driven from a table of commands with the following shapes:
- transmit and receive together;
- opcode with receive only;
- opcode alone;
- transmit only;
- two commands whose counts exceed the buffer.

These shapes separate a wrong phase order from a wrong length and a wrong write-back position. A bench device model returns a different byte for each receive slot, so a shifted store address shows up as a data mismatch. Directed tests cover the following:
- the reset state;
- single-byte lane writes;
- the self-clearing bits;
- writes made in the middle of a command, which must leave the registers unchanged.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DEPTH   = 64,
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PW   = $clog2(DEPTH);

  logic [7:0]    fifo [DEPTH];
  logic [7:0]    opcode, txcnt, rxcnt;
  logic [1:0]    csel;
  logic          busy, sclk_q;
  logic [CW-1:0] dcnt;
  logic [2:0]    bitn;
  logic [7:0]    bidx, txsh, rxsh;

  wire [7:0]    word     = bus_addr & 8'hFC;
  wire          acc      = bus_wr && !busy;
  wire          fifo_hit = (bus_addr >= 8'h80) && ({1'b0, bus_addr} < 9'(128 + DEPTH));
  wire [PW-1:0] fb       = PW'({bus_addr[6:2], 2'b00});
  wire          start    = acc && (word == 8'h00) && bus_be[2] && bus_wdata[16];

  wire [7:0] etx  = (txcnt > 8'(DEPTH)) ? 8'(DEPTH) : txcnt;
  wire [7:0] room = 8'(DEPTH) - etx;
  wire [7:0] erx  = (rxcnt > room) ? room : rxcnt;
  wire [7:0] last = etx + erx;

  wire       tick     = busy && (dcnt == CW'(HALF - 1));
  wire       byte_end = tick && sclk_q && (bitn == 3'd7);
  wire       rxph     = bidx > etx;
  wire [7:0] nb       = bidx + 8'd1;
  wire [7:0] nxt_byte = (nb <= etx) ? fifo[PW'(bidx)] : 8'h00;

  assign spi_sclk = sclk_q;
  assign spi_mosi = busy && !rxph && txsh[7];
  assign spi_cs_n = busy ? ~(4'b0001 << csel) : 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode <= '0;
      txcnt  <= '0;
      rxcnt  <= '0;
      csel   <= '0;
    end else if (acc) begin
      if (word == 8'h00 && bus_be[0]) opcode <= bus_wdata[7:0];
      if (word == 8'h1C && bus_be[1]) csel   <= bus_wdata[9:8];
      if (word == 8'h48 && bus_be[0]) txcnt  <= bus_wdata[7:0];
      if (word == 8'h48 && bus_be[3]) rxcnt  <= bus_wdata[31:24];
    end
  end

  always_ff @(posedge clk) begin
    if (acc && fifo_hit) begin
      for (int k = 0; k < 4; k++)
        if (bus_be[k]) fifo[fb + PW'(k)] <= bus_wdata[8*k +: 8];
    end else if (byte_end && rxph) begin
      fifo[PW'(bidx - 8'd1)] <= rxsh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_q <= 1'b0;
      dcnt   <= '0;
      bitn   <= '0;
      bidx   <= '0;
      txsh   <= '0;
      rxsh   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk_q <= 1'b0;
      dcnt   <= '0;
      bitn   <= '0;
      bidx   <= '0;
      txsh   <= bus_be[0] ? bus_wdata[7:0] : opcode;
    end else if (busy) begin
      dcnt <= tick ? '0 : dcnt + CW'(1);
      if (tick) begin
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          rxsh <= {rxsh[6:0], spi_miso};
        end else if (bitn == 3'd7) begin
          bitn <= '0;
          if (bidx == last) begin
            busy <= 1'b0;
          end else begin
            bidx <= nb;
            txsh <= nxt_byte;
          end
        end else begin
          bitn <= bitn + 3'd1;
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      8'h00:   bus_rdata = {busy, 23'b0, opcode};
      8'h1C:   bus_rdata = {22'b0, csel, 8'b0};
      8'h48:   bus_rdata = {rxcnt, 16'b0, txcnt};
      default: if (fifo_hit)
                 for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = fifo[fb + PW'(k)];
    endcase
  end
endmodule

module spi_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [7:0]  opcode,
  input logic [7:0]  txcnt,
  input logic [3:0]  spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi
);
  a_r7_one_cs: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~spi_cs_n));
  a_r7_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n) (&spi_cs_n) |-> !spi_sclk);
  a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(spi_cs_n));
  a_r5_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n) (&spi_cs_n) |-> !spi_mosi);
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr[7:2] == 6'd0 && bus_be[2] && bus_wdata[16]) |=> busy);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> ($stable(txcnt) && $stable(opcode)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk i_chk (.*);

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  spi_cmd_engine i_spi_cmd_engine (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int sl_bits = 0, sl_etx = 0;
  logic [7:0] cap [0:80];
  logic [3:0] cs_seen = 4'hF;
  realtime t_prev = 0, t_last = 0;

  function automatic logic [7:0] resp(input int j);
    return 8'(8'h3C + 8'h11 * j);
  endfunction

  always @(posedge spi_sclk) begin
    cap[sl_bits / 8][7 - (sl_bits % 8)] = spi_mosi;
    t_prev = t_last;
    t_last = $realtime;
  end
  always @(negedge spi_sclk) sl_bits = sl_bits + 1;
  always @(spi_cs_n) if (spi_cs_n != 4'hF) cs_seen = spi_cs_n;
  always_comb begin
    int by;
    logic [7:0] r;
    by = sl_bits / 8;
    r = resp(by - 1 - sl_etx);
    spi_miso = (by >= 1 + sl_etx) ? r[7 - (sl_bits % 8)] : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle;
    logic [31:0] d;
    int n = 0;
    do begin rd(8'h00, d); n++; end while (d[31] && n < 20000);
  endtask

  localparam logic [25:0] VEC [7] = '{
    {2'd0, 8'h03, 8'd3,  8'd4},
    {2'd2, 8'h9F, 8'd0,  8'd3},
    {2'd1, 8'h06, 8'd0,  8'd0},
    {2'd3, 8'h0B, 8'd5,  8'd0},
    {2'd1, 8'h02, 8'd60, 8'd10},
    {2'd2, 8'hD8, 8'd70, 8'd2},
    {2'd0, 8'h5A, 8'd1,  8'd1}
  };

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    chk("R1 cs_n", {28'b0, spi_cs_n}, 32'hF);
    chk("R1 sclk", {31'b0, spi_sclk}, 0);
    chk("R1 mosi", {31'b0, spi_mosi}, 0);
    rst_n = 1;

    // R2 byte lanes
    wr(8'h48, 4'b1111, 32'h0000_0011);
    wr(8'h4B, 4'b1000, 32'hAB00_0000);
    rd(8'h48, d); chk("R2 lane write", d, 32'hAB00_0011);
    wr(8'h84, 4'b0100, 32'h00C5_0000);
    wr(8'h84, 4'b0001, 32'h0000_0077);
    rd(8'h84, d); chk("R2 fifo lanes", {8'h0, d[23:16], 8'h0, d[7:0]}, 32'h00C5_0077);

    for (int v = 0; v < 7; v++) begin
      int cs, tx, rx, etx, erx;
      logic [7:0] op;
      cs = int'(VEC[v][25:24]); op = VEC[v][23:16];
      tx = int'(VEC[v][15:8]); rx = int'(VEC[v][7:0]);
      etx = tx > 64 ? 64 : tx;
      erx = rx > 64 - etx ? 64 - etx : rx;
      for (int i = 0; i < etx; i++)
        wr(8'(8'h80 + i), 4'(1 << (i % 4)), {4{8'(op ^ 8'(i * 7))}});
      wr(8'h48, 4'b1001, {8'(rx), 16'h0, 8'(tx)});
      wr(8'h1C, 4'b0010, {22'h0, 2'(cs), 8'h0});
      sl_bits = 0; sl_etx = etx; cs_seen = 4'hF;
      wr(8'h00, 4'b0101, {8'h00, 8'h01, 8'h00, op});
      rd(8'h00, d); chk("R4 busy set", {31'b0, d[31]}, 1);
      wait_idle();
      rd(8'h00, d);
      chk("R4 busy clear", {31'b0, d[31]}, 0);
      chk("R3 self clear", {30'b0, d[20], d[16]}, 0);
      chk("R5 R9 clock count", sl_bits, 8 * (1 + etx + erx));
      chk("R7 cs select", {28'b0, cs_seen}, {28'b0, ~(4'b1 << cs)});
      chk("R5 opcode", {24'b0, cap[0]}, {24'b0, op});
      for (int i = 0; i < etx; i++)
        chk("R5 tx byte", {24'b0, cap[1 + i]}, {24'b0, 8'(op ^ 8'(i * 7))});
      for (int j = 0; j < erx; j++) begin
        logic [7:0] a;
        chk("R5 mosi low rx", {24'b0, cap[1 + etx + j]}, 0);
        a = 8'(8'h80 + etx + j);
        rd(a, d);
        chk("R6 rx store", {24'b0, d[8 * (a % 4) +: 8]}, {24'b0, resp(j)});
      end
      if (v == 0) chk("R10 period", int'((t_last - t_prev) * 1000), 20000);
    end

    // R8 writes during busy ignored
    wr(8'h48, 4'b1001, {8'd20, 16'h0, 8'd2});
    wr(8'h80, 4'b0001, 32'h0000_0042);
    sl_bits = 0; sl_etx = 2;
    wr(8'h00, 4'b0101, 32'h0001_0033);
    wr(8'h00, 4'b0001, 32'h0000_0055);
    wr(8'h48, 4'b0001, 32'h0000_0009);
    wr(8'h80, 4'b0001, 32'h0000_00EE);
    wait_idle();
    rd(8'h00, d); chk("R8 opcode held", {24'b0, d[7:0]}, 32'h33);
    rd(8'h48, d); chk("R8 count held", {24'b0, d[7:0]}, 32'h02);
    rd(8'h80, d); chk("R8 fifo held", {24'b0, d[7:0]}, 32'h42);
    chk("R9 R5 short cmd", sl_bits, 8 * 23);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule